// File: doc/BRIEF.md
# Serial Control Word Port with Mode Selection and Channel Routing

This block receives 8-bit control words over a three-wire serial link (data, shift clock, latch strobe) and files each word into one of two holding registers: a 7-bit attenuation level or a set of mode flags. The top data bit of the word picks the register. All three serial lines come from off-chip. Each one passes through a two-flop synchronizer, and the block acts on rising edges that it finds in the synchronized copies. A serial clock slower than a few system clocks per half-period is therefore required.

A mode pin selects where the effective settings come from. When the pin is high, direct parallel pins supply the de-emphasis, soft-mute and bass-boost settings. When it is low, the latched flags supply them. In that flag-driven mode the block also drives a bass-boost status bit and can fold a stereo sample pair onto either channel for mono playback.

Top module: `sctl_port`

## Requirements
- R1: A bit is taken from the synchronized data line at each rising edge of the synchronized shift clock. The first bit taken ends up as bit 0 of the word and the eighth as bit 7. The registers change only on a rising edge of the synchronized latch line.
- R2: A latched word with bit 7 = 0 loads bits 6..0 into the attenuation output (bit 6 is the MSB) and leaves the flags unchanged.
- R3: A latched word with bit 7 = 1 loads the flags and leaves the attenuation unchanged. Bit 5 is de-emphasis, bit 4 is boost select A, bit 3 is boost select B, bit 2 is mono and bit 1 is channel select. Bits 6 and 0 have no effect.
- R4: Reset (synchronous, active high) sets the attenuation to 127 and every flag to 0.
- R5: With the mode pin high, de-emphasis, mute and the 2-bit boost code {A,B} follow the parallel pins. The status bit is 0 and the samples pass through as stereo.
- R6: With the mode pin low, de-emphasis and the boost code follow the flags and mute is 0.
- R7: With the mode pin low, the status bit is 0 only for boost code 11 (flat 0 dB). It is 1 for 10 (minimum boost), 01 (maximum boost) and 00 (flat at -8 dB).
- R8: With the mode pin low and mono set, channel select 1 puts the right sample on both outputs and channel select 0 puts the left sample on both. With mono clear, left goes to left and right goes to right.
- R9: Shifting a full word without a latch edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_lat_i | input | 1 | Serial latch strobe (asynchronous) |
| par_mode_i | input | 1 | 1 = parallel pins, 0 = serial flags |
| pin_deemph_i | input | 1 | Parallel de-emphasis enable |
| pin_mute_i | input | 1 | Parallel soft-mute request |
| pin_bb_a_i | input | 1 | Parallel boost select A |
| pin_bb_b_i | input | 1 | Parallel boost select B |
| left_i | input | SMP_W | Left input sample |
| right_i | input | SMP_W | Right input sample |
| deemph_o | output | 1 | Effective de-emphasis enable |
| mute_o | output | 1 | Effective soft-mute request |
| bb_code_o | output | 2 | Effective boost code {A,B} |
| bb_stat_o | output | 1 | Boost status (flag mode only) |
| atten_o | output | 7 | Attenuation register |
| left_o | output | SMP_W | Routed left sample |
| right_o | output | SMP_W | Routed right sample |

## Verification
The checker watches every cycle for four things: the attenuation or the flags changing on any cycle other than the one after a latch edge of the matching word type, the parallel pins reaching the outputs in parallel mode, mute being held low in flag mode, and the boost status and mono routing against the effective code and the samples. Only the bench scenarios can show that the bit order places the first bit at position 0, that unused bits 6 and 0 are ignored, that reset leaves the right values, and that a shifted word with no latch edge changes nothing. The bench checks these by driving whole serial transfers and comparing the outputs with a model of the registers.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int WORD_W = 8;
    localparam int ATT_W  = 7;
    localparam logic [ATT_W-1:0] ATT_RESET = '1;

    typedef enum logic [1:0] {
        BB_FLAT_LOW = 2'b00,
        BB_MAX      = 2'b01,
        BB_MIN      = 2'b10,
        BB_FLAT_0DB = 2'b11
    } bb_code_t;

    typedef struct packed {
        logic deemph;
        logic bb_a;
        logic bb_b;
        logic mono;
        logic chsel;
    } mode_flags_t;

    function automatic mode_flags_t word_to_flags(input logic [WORD_W-1:0] w);
        mode_flags_t f;
        f.deemph = w[5];
        f.bb_a   = w[4];
        f.bb_b   = w[3];
        f.mono   = w[2];
        f.chsel  = w[1];
        return f;
    endfunction

    function automatic logic bb_is_boosting(input bb_code_t c);
        return c != BB_FLAT_0DB;
    endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              shift_en,
    input  logic              latch_en,
    output logic [WORD_W-1:0] word_o,
    output logic [ATT_W-1:0]  atten_o,
    output mode_flags_t       flags_o
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            atten_o <= ATT_RESET;
            flags_o <= '0;
        end else begin
            if (shift_en)
                shreg <= {bit_in, shreg[WORD_W-1:1]};
            if (latch_en) begin
                if (shreg[WORD_W-1])
                    flags_o <= word_to_flags(shreg);
                else
                    atten_o <= shreg[ATT_W-1:0];
            end
        end
    end

    assign word_o = shreg;
endmodule

// File: rtl/sctl_select.sv
module sctl_select
    import sctl_pkg::*;
(
    input  logic        par_mode,
    input  logic        pin_deemph,
    input  logic        pin_mute,
    input  logic        pin_bb_a,
    input  logic        pin_bb_b,
    input  mode_flags_t flags,
    output logic        deemph,
    output logic        mute,
    output bb_code_t    bb_code,
    output logic        bb_stat,
    output logic        mono_en,
    output logic        chsel
);
    always_comb begin
        if (par_mode) begin
            deemph  = pin_deemph;
            mute    = pin_mute;
            bb_code = bb_code_t'({pin_bb_a, pin_bb_b});
            bb_stat = 1'b0;
            mono_en = 1'b0;
            chsel   = 1'b0;
        end else begin
            deemph  = flags.deemph;
            mute    = 1'b0;
            bb_code = bb_code_t'({flags.bb_a, flags.bb_b});
            bb_stat = bb_is_boosting(bb_code_t'({flags.bb_a, flags.bb_b}));
            mono_en = flags.mono;
            chsel   = flags.chsel;
        end
    end
endmodule

// File: rtl/sctl_route.sv
module sctl_route #(
    parameter int SMP_W = 16
) (
    input  logic             mono_en,
    input  logic             chsel,
    input  logic [SMP_W-1:0] left_i,
    input  logic [SMP_W-1:0] right_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o
);
    logic [SMP_W-1:0] mono_src;

    assign mono_src = chsel ? right_i : left_i;
    assign left_o   = mono_en ? mono_src : left_i;
    assign right_o  = mono_en ? mono_src : right_i;
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int SMP_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_lat_i,
    input  logic             par_mode_i,
    input  logic             pin_deemph_i,
    input  logic             pin_mute_i,
    input  logic             pin_bb_a_i,
    input  logic             pin_bb_b_i,
    input  logic [SMP_W-1:0] left_i,
    input  logic [SMP_W-1:0] right_i,
    output logic             deemph_o,
    output logic             mute_o,
    output logic [1:0]       bb_code_o,
    output logic             bb_stat_o,
    output logic [ATT_W-1:0] atten_o,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o
);
    localparam int N_LINES = 3;
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_LAT = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lvl;
    logic [N_LINES-1:0] sync_rise;

    assign raw_lines = {ser_lat_i, ser_dat_i, ser_clk_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        sctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .level(sync_lvl[g]),
            .rise (sync_rise[g])
        );
    end

    logic              lat_rise;
    logic [WORD_W-1:0] shift_word;
    mode_flags_t       flags_q;
    bb_code_t          bb_code;
    logic              mono_en;
    logic              chsel;

    assign lat_rise = sync_rise[IDX_LAT];

    sctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (sync_lvl[IDX_DAT]),
        .shift_en(sync_rise[IDX_CLK]),
        .latch_en(lat_rise),
        .word_o  (shift_word),
        .atten_o (atten_o),
        .flags_o (flags_q)
    );

    sctl_select u_sel (
        .par_mode  (par_mode_i),
        .pin_deemph(pin_deemph_i),
        .pin_mute  (pin_mute_i),
        .pin_bb_a  (pin_bb_a_i),
        .pin_bb_b  (pin_bb_b_i),
        .flags     (flags_q),
        .deemph    (deemph_o),
        .mute      (mute_o),
        .bb_code   (bb_code),
        .bb_stat   (bb_stat_o),
        .mono_en   (mono_en),
        .chsel     (chsel)
    );

    assign bb_code_o = bb_code;

    sctl_route #(.SMP_W(SMP_W)) u_route (
        .mono_en(mono_en),
        .chsel  (chsel),
        .left_i (left_i),
        .right_i(right_i),
        .left_o (left_o),
        .right_o(right_o)
    );
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk
    import sctl_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lat_rise,
    input logic [WORD_W-1:0] shift_word,
    input mode_flags_t      flags_q,
    input logic             par_mode_i,
    input logic             pin_deemph_i,
    input logic             pin_mute_i,
    input logic             pin_bb_a_i,
    input logic             pin_bb_b_i,
    input logic [SMP_W-1:0] left_i,
    input logic [SMP_W-1:0] right_i,
    input logic             deemph_o,
    input logic             mute_o,
    input logic [1:0]       bb_code_o,
    input logic             bb_stat_o,
    input logic [ATT_W-1:0] atten_o,
    input logic [SMP_W-1:0] left_o,
    input logic [SMP_W-1:0] right_o
);
    // R2
    atten_only_on_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (atten_o != $past(atten_o)) |-> ($past(lat_rise) && !$past(shift_word[WORD_W-1])));

    // R3
    flags_only_on_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q != $past(flags_q)) |-> ($past(lat_rise) && $past(shift_word[WORD_W-1])));

    // R5
    par_pins_pass_chk: assert property (@(posedge clk) disable iff (rst)
        par_mode_i |-> (deemph_o == pin_deemph_i && mute_o == pin_mute_i &&
                        bb_code_o == {pin_bb_a_i, pin_bb_b_i} && !bb_stat_o &&
                        left_o == left_i && right_o == right_i));

    // R6
    flag_mode_no_mute_chk: assert property (@(posedge clk) disable iff (rst)
        !par_mode_i |-> !mute_o);

    // R7
    boost_status_chk: assert property (@(posedge clk) disable iff (rst)
        !par_mode_i |-> (bb_stat_o == (bb_code_o != 2'b11)));

    // R8
    routing_source_chk: assert property (@(posedge clk) disable iff (rst)
        (left_o == left_i || left_o == right_i) && (right_o == right_i || right_o == left_i));
endmodule

bind sctl_port sctl_port_chk #(.SMP_W(SMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lat_rise    (lat_rise),
    .shift_word  (shift_word),
    .flags_q     (flags_q),
    .par_mode_i  (par_mode_i),
    .pin_deemph_i(pin_deemph_i),
    .pin_mute_i  (pin_mute_i),
    .pin_bb_a_i  (pin_bb_a_i),
    .pin_bb_b_i  (pin_bb_b_i),
    .left_i      (left_i),
    .right_i     (right_i),
    .deemph_o    (deemph_o),
    .mute_o      (mute_o),
    .bb_code_o   (bb_code_o),
    .bb_stat_o   (bb_stat_o),
    .atten_o     (atten_o),
    .left_o      (left_o),
    .right_o     (right_o)
);

// File: tb/tb_sctl_port.sv
module tb_sctl_port;
    localparam int SMP_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic par_mode = 1'b0;
    logic p_deemph = 1'b0, p_mute = 1'b0, p_a = 1'b0, p_b = 1'b0;
    logic [SMP_W-1:0] lin = '0, rin = '0;
    logic deemph_o, mute_o, bb_stat_o;
    logic [1:0] bb_code_o;
    logic [6:0] atten_o;
    logic [SMP_W-1:0] lout, rout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [6:0] m_att;
    logic m_de, m_a, m_b, m_mono, m_cs;

    always #4 clk = ~clk;

    sctl_port #(.SMP_W(SMP_W)) dut (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_lat_i(ser_lat),
        .par_mode_i(par_mode),
        .pin_deemph_i(p_deemph), .pin_mute_i(p_mute),
        .pin_bb_a_i(p_a), .pin_bb_b_i(p_b),
        .left_i(lin), .right_i(rin),
        .deemph_o(deemph_o), .mute_o(mute_o), .bb_code_o(bb_code_o),
        .bb_stat_o(bb_stat_o), .atten_o(atten_o),
        .left_o(lout), .right_o(rout)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int i = 0; i < 8; i++) begin
            ser_dat = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic latch_pulse();
        wait_clk(4);
        ser_lat = 1'b1;
        wait_clk(4);
        ser_lat = 1'b0;
        wait_clk(6);
    endtask

    function automatic void model_update(input logic [7:0] w);
        if (w[7]) begin
            m_de = w[5]; m_a = w[4]; m_b = w[3]; m_mono = w[2]; m_cs = w[1];
        end else begin
            m_att = w[6:0];
        end
    endfunction

    function automatic int exp_left(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
        if (m_mono) return m_cs ? int'(r) : int'(l);
        return int'(l);
    endfunction

    function automatic int exp_right(input logic [SMP_W-1:0] l, input logic [SMP_W-1:0] r);
        if (m_mono) return m_cs ? int'(r) : int'(l);
        return int'(r);
    endfunction

    task automatic check_flag_mode(input string tag);
        @(negedge clk);
        chk("R2", {tag, " atten"}, atten_o, m_att);
        chk("R6", {tag, " deemph"}, deemph_o, m_de);
        chk("R6", {tag, " mute"}, mute_o, 0);
        chk("R3", {tag, " bb code"}, bb_code_o, {m_a, m_b});
        chk("R7", {tag, " bb status"}, bb_stat_o, ({m_a, m_b} != 2'b11) ? 1 : 0);
        chk("R8", {tag, " left"}, lout, exp_left(lin, rin));
        chk("R8", {tag, " right"}, rout, exp_right(lin, rin));
    endtask

    task automatic send(input logic [7:0] w, input string tag);
        shift_word(w);
        latch_pulse();
        model_update(w);
        lin = SMP_W'($urandom);
        rin = SMP_W'($urandom);
        check_flag_mode(tag);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_att = 7'd127; m_de = 0; m_a = 0; m_b = 0; m_mono = 0; m_cs = 0;
        lin = 16'h1234; rin = 16'hABCD;
        wait_clk(5);
        rst = 1'b0;
        // R4: reset values seen in flag mode
        check_flag_mode("R4 reset");
        chk("R4", "reset atten", atten_o, 127);

        // R2: attenuation boundaries
        send(8'h00, "R2 zero");
        send(8'h7F, "R2 full");
        send(8'h55, "R2 pattern");
        // R1: bit order, 0x01 -> atten 1 (first bit is LSB)
        send(8'h01, "R1 lsb first");
        chk("R1", "lsb first atten", atten_o, 1);

        // R3: all flags set, mono right
        send(8'hFF, "R3 all flags");
        chk("R8", "mono right on left out", lout, rin);
        // R3: only unused bits 6 and 0 set -> flags all zero
        send(8'hC1, "R3 unused bits");
        chk("R3", "unused bits keep atten", atten_o, 1);
        // R7: each boost code
        send(8'h98, "R7 code11");
        send(8'h90, "R7 code10");
        send(8'h88, "R7 code01");
        send(8'h80, "R7 code00");
        // R8: mono left, then stereo
        send(8'h84, "R8 mono left");
        send(8'h86, "R8 mono right");
        send(8'h80, "R8 stereo");

        // R9: full word shifted, no latch
        shift_word(8'h00);
        wait_clk(10);
        check_flag_mode("R9 no latch");
        chk("R9", "atten held", atten_o, 1);

        // R5: parallel mode with every pin combination
        par_mode = 1'b1;
        for (int k = 0; k < 16; k++) begin
            {p_deemph, p_mute, p_a, p_b} = 4'(k);
            lin = SMP_W'($urandom);
            rin = SMP_W'($urandom);
            @(negedge clk);
            chk("R5", "par deemph", deemph_o, p_deemph);
            chk("R5", "par mute", mute_o, p_mute);
            chk("R5", "par bb code", bb_code_o, {p_a, p_b});
            chk("R5", "par status", bb_stat_o, 0);
            chk("R5", "par left", lout, lin);
            chk("R5", "par right", rout, rin);
        end
        par_mode = 1'b0;

        // random words
        for (int n = 0; n < 60; n++) begin
            send(8'($urandom), "rand");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule